// File: doc/BRIEF.md
# Two-Way Packet Routing Fork

This block is one element of a ring-style packet bus. It has one input port and two output ports, called main and shortcut. Every port uses a valid/ready handshake, and a word moves only in a cycle where both valid and ready are high. Packets are one or more words long. The first word of each packet is the header. The fork decodes the header and sends the header and the whole body to one of the two outputs.

The header carries two fields. The destination identifier sits in bits `[DEST_W-1:0]`. The body length sits in bits `[DEST_W+LEN_W-1:DEST_W]` and counts the words that follow the header, so a value of 0 means a single-word packet. The parameter `SC_MASK` holds one bit per destination. A destination whose bit is set goes to the shortcut output, and every other destination goes to the main output.

The datapath has no storage. Data is broadcast to both outputs, and valid is raised only on the selected output. Input ready is the ready of the selected output.

Control is a three-state machine:
- `ST_HEAD`: waiting for a header. In this state the selected path comes straight from the incoming header.
- `ST_MAIN`: the path is locked to the main output for the rest of a packet body.
- `ST_SHORT`: the path is locked to the shortcut output for the rest of a packet body.

Its transitions are:
- `HEAD_TO_MAIN` / `HEAD_TO_SHORT`: a header with a nonzero length is accepted.
- `HEAD_STAY`: no header is accepted, or a zero-length header is accepted.
- `BODY_HOLD`: a body word is accepted but is not the last one, or no body word is accepted.
- `MAIN_TO_HEAD` / `SHORT_TO_HEAD`: the last body word is accepted.

Top module: `pkt_fork`

## Requirements
- R1: After reset, and after a reset that arrives in the middle of a packet, the next input word is treated as a header.
- R2: A header whose destination field (bits [3:0] by default) has its bit set in SC_MASK is routed to the shortcut output. Any other header is routed to the main output.
- R3: The length field in header bits [7:4] (by default) gives the number of body words that follow. A packet is exactly length+1 words, and the word after it is decoded as a new header.
- R4: Every body word leaves on the same output as its header, whatever bit pattern the body word carries.
- R5: Input ready equals the ready of the selected output. The ready of the unselected output has no effect.
- R6: The valid of the unselected output is low, so the two output valids are never high together.
- R7: The data on the selected output equals the input word in the same cycle, so words keep their order.
- R8: A zero-length header forms a complete packet. The very next word is again decoded as a header and may take the other path.
- R9: A packet with the largest length (2^LEN_W-1 body words) is carried whole on one path.
- R10: Cycles with input valid low do not advance the packet, and both output valids are low in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Fork can take the input word |
| in_data | input | DATA_W | Input word (header or body) |
| main_valid | output | 1 | Word present on main output |
| main_ready | input | 1 | Main downstream can take a word |
| main_data | output | DATA_W | Main output word |
| short_valid | output | 1 | Word present on shortcut output |
| short_ready | input | 1 | Shortcut downstream can take a word |
| short_data | output | DATA_W | Shortcut output word |

## Verification
The bench targets the following corner cases, and each one names the failure it would expose:
- Body words that look like headers for the other path. A fork that re-decodes every word would split the packet.
- A stalled selected output while the unselected output stays ready. A fork that listens to the wrong ready would drop words or accept words it cannot deliver.
- Zero-length packets sent back to back with alternating destinations. An off-by-one in the length count would glue two packets onto one path.
- Packets of the largest length. A counter that is too narrow would end the packet early.
- Input bubbles in the middle of a packet. These would advance a count that ignores valid.
- A reset in the middle of a packet. This would leave a path locked that should have been freed.

// File: rtl/fork_pkg.sv
package fork_pkg;
    typedef enum logic [1:0] {
        ST_HEAD  = 2'd0,
        ST_MAIN  = 2'd1,
        ST_SHORT = 2'd2
    } fork_state_e;

    typedef enum logic {
        PATH_MAIN  = 1'b0,
        PATH_SHORT = 1'b1
    } fork_path_e;
endpackage

// File: rtl/fork_hdr_decode.sv
module fork_hdr_decode #(
    parameter int DATA_W = 32,
    parameter int DEST_W = 4,
    parameter int LEN_W  = 4,
    parameter logic [(1<<DEST_W)-1:0] SC_MASK = '0
) (
    input  logic [DATA_W-1:0] word,
    output logic              hdr_short,
    output logic [LEN_W-1:0]  hdr_len
);
    localparam int NDEST = 1 << DEST_W;

    logic [DEST_W-1:0] dest;
    logic [NDEST-1:0]  hit_vec;

    assign dest    = word[DEST_W-1:0];
    assign hdr_len = word[DEST_W +: LEN_W];

    for (genvar g = 0; g < NDEST; g++) begin : g_match
        assign hit_vec[g] = SC_MASK[g] && (dest == DEST_W'(g));
    end

    assign hdr_short = |hit_vec;
endmodule

// File: rtl/fork_ctrl.sv
module fork_ctrl
    import fork_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_ready,
    input  logic             hdr_short,
    input  logic [LEN_W-1:0] hdr_len,
    output fork_path_e       sel
);
    fork_state_e      state_q, state_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    logic             fire;

    assign fire = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HEAD;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_HEAD: begin
                if (fire && hdr_len != '0) begin
                    state_d = hdr_short ? ST_SHORT : ST_MAIN;
                    cnt_d   = hdr_len;
                end
            end
            ST_MAIN, ST_SHORT: begin
                if (fire) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == LEN_W'(1)) state_d = ST_HEAD;
                end
            end
            default: begin
                state_d = ST_HEAD;
                cnt_d   = '0;
            end
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_HEAD:  sel = hdr_short ? PATH_SHORT : PATH_MAIN;
            ST_MAIN:  sel = PATH_MAIN;
            ST_SHORT: sel = PATH_SHORT;
            default:  sel = PATH_MAIN;
        endcase
    end

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_ready) |=> ($stable(state_q) && $stable(cnt_q)));

    assert_main_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN && !(fire && cnt_q == LEN_W'(1))) |=> state_q == ST_MAIN);

    assert_short_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHORT && !(fire && cnt_q == LEN_W'(1))) |=> state_q == ST_SHORT);

    assert_head_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HEAD) |-> (cnt_q == '0));
endmodule

// File: rtl/fork_steer.sv
module fork_steer
    import fork_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fork_path_e        sel,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic [1:0]        out_ready,
    output logic [1:0]        out_valid,
    output logic [DATA_W-1:0] out_data [2]
);
    localparam int NPORT = 2;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign out_valid[p] = in_valid && (sel == fork_path_e'(p));
        assign out_data[p]  = in_data;
    end

    assign in_ready = out_ready[sel];

    always_comb begin
        assert_excl_valid_R6: assert ($countones(out_valid) <= 1);
    end
endmodule

// File: rtl/pkt_fork.sv
module pkt_fork
    import fork_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEST_W = 4,
    parameter int LEN_W  = 4,
    parameter logic [(1<<DEST_W)-1:0] SC_MASK = 16'h0C30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              main_valid,
    input  logic              main_ready,
    output logic [DATA_W-1:0] main_data,
    output logic              short_valid,
    input  logic              short_ready,
    output logic [DATA_W-1:0] short_data
);
    fork_path_e        sel;
    logic              hdr_short;
    logic [LEN_W-1:0]  hdr_len;
    logic [1:0]        out_valid;
    logic [DATA_W-1:0] out_data [2];

    fork_hdr_decode #(
        .DATA_W(DATA_W), .DEST_W(DEST_W), .LEN_W(LEN_W), .SC_MASK(SC_MASK)
    ) u_dec (
        .word(in_data), .hdr_short(hdr_short), .hdr_len(hdr_len)
    );

    fork_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .hdr_short(hdr_short), .hdr_len(hdr_len), .sel(sel)
    );

    fork_steer #(.DATA_W(DATA_W)) u_steer (
        .sel(sel), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_ready({short_ready, main_ready}), .out_valid(out_valid),
        .out_data(out_data)
    );

    assign main_valid  = out_valid[0];
    assign short_valid = out_valid[1];
    assign main_data   = out_data[0];
    assign short_data  = out_data[1];

    assert_bubble_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!main_valid && !short_valid));

    assert_ready_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (main_valid && main_ready) |-> in_ready);
endmodule

// File: tb/pkt_fork_bench.sv
module pkt_fork_bench;
    localparam int DATA_W = 32;
    localparam logic [15:0] MASK = 16'h0C30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, main_ready = 1'b0, short_ready = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_ready, main_valid, short_valid;
    logic [DATA_W-1:0] main_data, short_data;

    int n_vec = 0;
    int n_bad = 0;
    int wd    = 0;

    // reference model state
    int m_rem   = 0;
    bit m_short = 1'b0;

    always #10 clk = ~clk;

    pkt_fork #(.DATA_W(DATA_W), .DEST_W(4), .LEN_W(4), .SC_MASK(MASK)) u_pkt_fork (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .main_valid(main_valid), .main_ready(main_ready),
        .main_data(main_data), .short_valid(short_valid),
        .short_ready(short_ready), .short_data(short_data)
    );

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual still running, expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic step(input logic v, input logic [31:0] d, input logic mr,
                        input logic sr, input string tag, output bit acc);
        bit route, e_rdy, e_mv, e_sv, bad;
        @(negedge clk);
        in_valid = v; in_data = d; main_ready = mr; short_ready = sr;
        #1;
        route = (m_rem == 0) ? MASK[d[3:0]] : m_short;
        e_rdy = route ? sr : mr;
        e_mv  = v && !route;
        e_sv  = v && route;
        bad = (in_ready !== e_rdy) || (main_valid !== e_mv) || (short_valid !== e_sv)
              || (e_mv && main_data !== d) || (e_sv && short_data !== d);
        n_vec++;
        if (bad) begin
            n_bad++;
            $display("FAIL %s: actual rdy=%b mv=%b sv=%b md=%h sd=%h expected rdy=%b mv=%b sv=%b data=%h",
                     tag, in_ready, main_valid, short_valid, main_data, short_data,
                     e_rdy, e_mv, e_sv, d);
        end
        acc = v && e_rdy;
        if (acc) begin
            if (m_rem == 0) begin
                m_short = route;
                m_rem   = int'(d[7:4]);
            end else begin
                m_rem--;
            end
        end
    endtask

    // mode bit0: input bubbles, bit1: random readies, bit2: unselected ready held low
    task automatic send_pkt(input logic [3:0] dest, input logic [3:0] len,
                            input logic [3:0] body_dest, input int mode, input string tag);
        logic [31:0] w;
        bit sc, acc, v, rs, ro;
        sc = MASK[dest];
        for (int i = 0; i <= int'(len); i++) begin
            w = (i == 0) ? {$urandom_range(0, 32'hFFFFFF), len, dest}
                         : {$urandom_range(0, 32'hFFFFFF), 4'(i), body_dest};
            acc = 1'b0;
            while (!acc) begin
                v  = !((mode & 1) != 0 && ($urandom_range(0, 3) == 0));
                rs = ((mode & 2) != 0) ? ($urandom_range(0, 2) != 0) : 1'b1;
                ro = ((mode & 4) != 0) ? 1'b0 : (((mode & 2) != 0) ? $urandom_range(0, 1) == 1 : 1'b1);
                step(v, w, sc ? ro : rs, sc ? rs : ro, tag, acc);
            end
        end
    endtask

    initial begin
        bit acc;
        void'($urandom(7));
        // R1: reset state, outputs quiet
        repeat (2) @(posedge clk);
        #1;
        n_vec++;
        if (main_valid !== 1'b0 || short_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R1 reset: actual mv=%b sv=%b expected 0 0", main_valid, short_valid);
        end
        @(negedge clk); rst_n = 1'b1;

        // R1 R2 R8: first word after reset is a header, single-word main packet
        send_pkt(4'd1, 4'd0, 4'd0, 0, "R1_R8 first header");
        // R2 R4 R3: shortcut packet whose body looks like main headers
        send_pkt(4'd4, 4'd3, 4'd1, 0, "R4 shortcut body lookalike");
        // R4 R5: main packet, bodies look like shortcut headers, stalls, shortcut ready low
        send_pkt(4'd2, 4'd5, 4'd10, 6, "R5 stall selected main");
        send_pkt(4'd11, 4'd4, 4'd3, 6, "R5 stall selected short");
        // R10: bubbles in the middle of packets
        send_pkt(4'd5, 4'd6, 4'd0, 1, "R10 bubbles short");
        send_pkt(4'd0, 4'd6, 4'd4, 3, "R10 bubbles main");
        // R9: largest length on each path
        send_pkt(4'd10, 4'd15, 4'd7, 2, "R9 max short");
        send_pkt(4'd7, 4'd15, 4'd5, 0, "R9 max main");
        // R8 R7: back-to-back single-word packets alternating path
        for (int k = 0; k < 8; k++)
            send_pkt((k % 2) ? 4'd4 : 4'd6, 4'd0, 4'd0, 0, "R8 back to back");

        // R1: reset in the middle of a shortcut packet
        step(1'b1, {24'h0, 4'd8, 4'd5}, 1'b1, 1'b1, "R1 pre-reset hdr", acc);
        step(1'b1, {24'h0, 4'd1, 4'd2}, 1'b1, 1'b1, "R1 pre-reset body", acc);
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        m_rem = 0; m_short = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        send_pkt(4'd3, 4'd2, 4'd4, 0, "R1 header after mid reset");

        // R2 R7: sweep of all destinations with mixed traffic
        for (int k = 0; k < 48; k++)
            send_pkt(4'(k % 16), 4'($urandom_range(0, 5)), 4'($urandom_range(0, 15)),
                     $urandom_range(0, 7), "R2_R7 sweep");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule